// File: doc/BRIEF.md
# Register Dependence Scoreboard

This block keeps one pending-write flag for each architectural register of an in-order pipelined processor and tells the register-read stage whether the instruction in front of it must wait. When an instruction that produces a result leaves register read, its destination is flagged. When writeback commits a value, that register's flag is dropped. Each cycle the read stage presents up to two source register indices. Each source carries a flag saying whether the instruction uses it at all, and a flag saying whether the forwarding network is driving that register's value right now. The block answers with a single stall signal.

The flags are registered. A flag change requested in one cycle shows in the stall answer from the next cycle on. The query itself is combinational on the registered flags. Register 0 always reads as zero and never holds a pending write. If a flag and an unflag name the same register in the same cycle, the register stays flagged, because the newer producer has not yet written back.

Top module: `dep_scoreboard`

## Requirements
- R1: Synchronous active-high reset clears every pending flag. After reset, no source index causes a stall.
- R2: When `iss_valid` is 1 with nonzero `iss_rd`, that register is pending from the next cycle on.
- R3: When `wb_valid` is 1, register `wb_rd` is no longer pending from the next cycle on, unless R5 applies. A writeback does not clear the flag in its own cycle.
- R4: `stall` is 1 when a used source (`*_used`=1) names a pending register and its bypass flag (`*_byp`) is 0.
- R5: When an issue and a writeback name the same register in the same cycle, the register stays pending.
- R6: A pending source whose bypass flag is 1 does not by itself cause a stall.
- R7: `stall` is 0 exactly when each of the two sources is unused, not pending, or bypassed.
- R8: A source with its used flag at 0 never causes a stall, whatever its index.
- R9: Register 0 is never pending. An issue naming register 0 has no effect, and a source index of 0 never stalls.
- R10: An issue and a writeback naming different registers in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | An instruction that writes a register is issuing |
| iss_rd | input | 5 | Destination index of the issuing instruction |
| wb_valid | input | 1 | Writeback is updating a register |
| wb_rd | input | 5 | Index of the register being written back |
| src_a_idx | input | 5 | First source register index |
| src_a_used | input | 1 | First source is read by the instruction |
| src_a_byp | input | 1 | First source value is present on the bypass path |
| src_b_idx | input | 5 | Second source register index |
| src_b_used | input | 1 | Second source is read by the instruction |
| src_b_byp | input | 1 | Second source value is present on the bypass path |
| stall | output | 1 | Register read must hold the instruction this cycle |

## Verification
The hardest situation to reach is a single cycle in which an issue and a writeback name the same register. It has to be followed at once by a query on that register with its bypass flag low. Only that query shows whether the register stayed pending or was cleared. The stimulus table places the collision on one row and the probing query on the row after it. The table also covers the case of one source pending and bypassed while the other is pending and not bypassed, which shows that each source is judged on its own. The flag visibility delay is checked by querying a register in the same cycle as its writeback, when it must still stall, and again in the following cycle, when it must not.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    localparam int NUM_REGS = 32;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int NUM_SRCS = 2;

    typedef logic [IDX_W-1:0]    reg_idx_t;
    typedef logic [NUM_REGS-1:0] busy_vec_t;

    // one operand of a read-stage query
    typedef struct packed {
        reg_idx_t idx;
        logic     used;
        logic     byp;
    } src_query_t;

    // a request to change one pending flag
    typedef struct packed {
        logic     en;
        reg_idx_t idx;
    } flag_req_t;

    // an operand blocks issue when it is read, pending and not forwarded
    function automatic logic src_blocks(input src_query_t q, input logic pending);
        return q.used && pending && !q.byp;
    endfunction

endpackage

// File: rtl/dsb_flag_file.sv
module dsb_flag_file
    import dsb_pkg::*;
#(
    parameter int NREGS = NUM_REGS,
    parameter int IW    = IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [IW-1:0]    set_idx,
    input  logic             clr_en,
    input  logic [IW-1:0]    clr_idx,
    output logic [NREGS-1:0] busy
);

    for (genvar g = 0; g < NREGS; g++) begin : g_flag
        if (g == 0) begin : g_zero
            // register zero is constant and never pending
            assign busy[g] = 1'b0;
        end else begin : g_cell
            logic hit_set;
            logic hit_clr;
            logic flag_q;

            assign hit_set = set_en && (set_idx == IW'(g));
            assign hit_clr = clr_en && (clr_idx == IW'(g));

            always_ff @(posedge clk) begin
                if (rst)          flag_q <= 1'b0;
                else if (hit_set) flag_q <= 1'b1;  // newer producer wins
                else if (hit_clr) flag_q <= 1'b0;
            end

            assign busy[g] = flag_q;
        end
    end

endmodule

// File: rtl/dsb_src_gate.sv
module dsb_src_gate
    import dsb_pkg::*;
(
    input  src_query_t q,
    input  busy_vec_t  busy,
    output logic       blocked
);

    logic pending;

    assign pending = busy[q.idx];
    assign blocked = src_blocks(q, pending);

endmodule

// File: rtl/dep_scoreboard.sv
module dep_scoreboard
    import dsb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       iss_valid,
    input  logic [4:0] iss_rd,
    input  logic       wb_valid,
    input  logic [4:0] wb_rd,
    input  logic [4:0] src_a_idx,
    input  logic       src_a_used,
    input  logic       src_a_byp,
    input  logic [4:0] src_b_idx,
    input  logic       src_b_used,
    input  logic       src_b_byp,
    output logic       stall
);

    flag_req_t  set_req;
    flag_req_t  clr_req;
    busy_vec_t  busy_q;
    src_query_t srcs [NUM_SRCS];
    logic [NUM_SRCS-1:0] blocked;

    assign set_req = '{en: iss_valid, idx: iss_rd};
    assign clr_req = '{en: wb_valid,  idx: wb_rd};

    assign srcs[0] = '{idx: src_a_idx, used: src_a_used, byp: src_a_byp};
    assign srcs[1] = '{idx: src_b_idx, used: src_b_used, byp: src_b_byp};

    dsb_flag_file #(
        .NREGS (NUM_REGS),
        .IW    (IDX_W)
    ) u_flags (
        .clk     (clk),
        .rst     (rst),
        .set_en  (set_req.en),
        .set_idx (set_req.idx),
        .clr_en  (clr_req.en),
        .clr_idx (clr_req.idx),
        .busy    (busy_q)
    );

    for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
        dsb_src_gate u_gate (
            .q       (srcs[s]),
            .busy    (busy_q),
            .blocked (blocked[s])
        );
    end

    assign stall = |blocked;

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker
    import dsb_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       iss_valid,
    input logic [4:0] iss_rd,
    input logic       wb_valid,
    input logic [4:0] wb_rd,
    input logic [4:0] src_a_idx,
    input logic       src_a_used,
    input logic       src_a_byp,
    input logic [4:0] src_b_idx,
    input logic       src_b_used,
    input logic       src_b_byp,
    input logic       stall,
    input busy_vec_t  busy
);

    // R1
    reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy == '0) && !stall);

    // R2
    issue_sets_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && iss_rd != 5'd0) |=> busy[$past(iss_rd)]);

    // R3
    wb_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !(iss_valid && iss_rd == wb_rd)) |=> !busy[$past(wb_rd)]);

    // R5
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (iss_valid && wb_valid && iss_rd == wb_rd && iss_rd != 5'd0) |=> busy[$past(iss_rd)]);

    // R4
    raw_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (src_a_used && busy[src_a_idx] && !src_a_byp) |-> stall);

    // R7
    all_covered_chk: assert property (@(posedge clk) disable iff (rst)
        ((!src_a_used || src_a_byp || !busy[src_a_idx]) &&
         (!src_b_used || src_b_byp || !busy[src_b_idx])) |-> !stall);

    // R8
    unused_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!src_a_used && !src_b_used) |-> !stall);

    // R9
    zero_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !busy[0]);

endmodule

bind dep_scoreboard dsb_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .iss_valid  (iss_valid),
    .iss_rd     (iss_rd),
    .wb_valid   (wb_valid),
    .wb_rd      (wb_rd),
    .src_a_idx  (src_a_idx),
    .src_a_used (src_a_used),
    .src_a_byp  (src_a_byp),
    .src_b_idx  (src_b_idx),
    .src_b_used (src_b_used),
    .src_b_byp  (src_b_byp),
    .stall      (stall),
    .busy       (busy_q)
);

// File: tb/dep_scoreboard_tb.sv
module dep_scoreboard_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [4:0] iss_rd = '0;
    logic       wb_valid = 1'b0;
    logic [4:0] wb_rd = '0;
    logic [4:0] src_a_idx = '0;
    logic       src_a_used = 1'b0;
    logic       src_a_byp = 1'b0;
    logic [4:0] src_b_idx = '0;
    logic       src_b_used = 1'b0;
    logic       src_b_byp = 1'b0;
    logic       stall;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    dep_scoreboard u_dut (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_rd(iss_rd),
        .wb_valid(wb_valid), .wb_rd(wb_rd),
        .src_a_idx(src_a_idx), .src_a_used(src_a_used), .src_a_byp(src_a_byp),
        .src_b_idx(src_b_idx), .src_b_used(src_b_used), .src_b_byp(src_b_byp),
        .stall(stall)
    );

    // row: iss_v iss_rd wb_v wb_rd | a_idx a_used a_byp | b_idx b_used b_byp | exp_stall
    // stall is judged on the flags held before this row's clock edge
    localparam int NV = 19;
    localparam logic [26:0] VEC [NV] = '{
        {1'b1,5'd3, 1'b0,5'd0,  5'd3, 1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b0}, // 0  R2 not yet visible
        {1'b0,5'd0, 1'b0,5'd0,  5'd3, 1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b1}, // 1  R4
        {1'b0,5'd0, 1'b0,5'd0,  5'd3, 1'b1,1'b1,  5'd0, 1'b0,1'b0, 1'b0}, // 2  R6
        {1'b0,5'd0, 1'b0,5'd0,  5'd5, 1'b1,1'b0,  5'd3, 1'b1,1'b0, 1'b1}, // 3  R4 second source
        {1'b0,5'd0, 1'b0,5'd0,  5'd5, 1'b1,1'b0,  5'd3, 1'b0,1'b0, 1'b0}, // 4  R8
        {1'b1,5'd7, 1'b1,5'd3,  5'd7, 1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b0}, // 5  R10
        {1'b0,5'd0, 1'b0,5'd0,  5'd3, 1'b1,1'b0,  5'd7, 1'b1,1'b0, 1'b1}, // 6  R10 / R3
        {1'b1,5'd9, 1'b1,5'd9,  5'd3, 1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b0}, // 7  R3 cleared
        {1'b0,5'd0, 1'b0,5'd0,  5'd9, 1'b1,1'b0,  5'd7, 1'b1,1'b1, 1'b1}, // 8  R5
        {1'b0,5'd0, 1'b0,5'd0,  5'd9, 1'b1,1'b1,  5'd7, 1'b1,1'b1, 1'b0}, // 9  R7
        {1'b1,5'd0, 1'b0,5'd0,  5'd0, 1'b1,1'b0,  5'd0, 1'b1,1'b0, 1'b0}, // 10 R9
        {1'b0,5'd0, 1'b0,5'd0,  5'd0, 1'b1,1'b0,  5'd0, 1'b1,1'b0, 1'b0}, // 11 R9
        {1'b0,5'd0, 1'b1,5'd7,  5'd7, 1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b1}, // 12 R3 same cycle
        {1'b0,5'd0, 1'b0,5'd0,  5'd7, 1'b1,1'b0,  5'd9, 1'b0,1'b0, 1'b0}, // 13 R3 / R8
        {1'b0,5'd0, 1'b1,5'd9,  5'd0, 1'b0,1'b0,  5'd9, 1'b1,1'b0, 1'b1}, // 14 R4 second source
        {1'b1,5'd31,1'b0,5'd0,  5'd9, 1'b1,1'b0,  5'd9, 1'b1,1'b0, 1'b0}, // 15 R3
        {1'b0,5'd0, 1'b0,5'd0,  5'd31,1'b1,1'b0,  5'd0, 1'b0,1'b0, 1'b1}, // 16 R2 top index
        {1'b0,5'd0, 1'b0,5'd0,  5'd31,1'b0,1'b0,  5'd31,1'b0,1'b0, 1'b0}, // 17 R8
        {1'b0,5'd0, 1'b0,5'd0,  5'd31,1'b1,1'b0,  5'd31,1'b1,1'b1, 1'b1}  // 18 R7
    };
    string tags [NV] = '{"R2","R4","R6","R4","R8","R10","R10","R3","R5","R7",
                         "R9","R9","R3","R3","R4","R3","R2","R8","R7"};

    task automatic check(input string req, input logic exp);
        total++;
        if (stall !== exp) begin
            bad++;
            $display("FAIL %s: stall=%b expected=%b", req, stall, exp);
        end
    endtask

    task automatic drive(input logic [26:0] v);
        @(negedge clk);
        {iss_valid, iss_rd, wb_valid, wb_rd,
         src_a_idx, src_a_used, src_a_byp,
         src_b_idx, src_b_used, src_b_byp} = v[26:1];
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: after reset no register is pending
        for (int r = 0; r < 32; r++) begin
            drive({1'b0,5'd0, 1'b0,5'd0, 5'(r),1'b1,1'b0, 5'(r),1'b1,1'b0, 1'b0});
            check("R1", 1'b0);
        end

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            check(tags[i], VEC[i][0]);
        end

        // R1: reset drops a pending flag (register 31 is pending here)
        drive({1'b0,5'd0, 1'b0,5'd0, 5'd31,1'b1,1'b0, 5'd0,1'b0,1'b0, 1'b0});
        check("R1", 1'b1);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive({1'b0,5'd0, 1'b0,5'd0, 5'd31,1'b1,1'b0, 5'd0,1'b0,1'b0, 1'b0});
        check("R1", 1'b0);

        // R5 with an idle read port: a collision on register 12 leaves it pending
        drive({1'b1,5'd12, 1'b1,5'd12, 5'd0,1'b0,1'b0, 5'd0,1'b0,1'b0, 1'b0});
        drive({1'b0,5'd0, 1'b0,5'd0, 5'd0,1'b0,1'b0, 5'd12,1'b1,1'b0, 1'b0});
        check("R5", 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: done=0 expected=1");
            end
        join_any
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule